// File: doc/BRIEF.md
# Stored Token Burst Sequencer

This block replays a list of pre-formed two-flit tokens from a local memory onto a token bus. A single trigger supplies a base word address and a token count. The block then reads consecutive 16-bit memory words starting at the base address and sends each word out as one flit. The word at an even offset from the base is the first flit of a token, which carries a command or destination tag. The word after it is the second flit, which carries routing or data.

Flits leave the block unchanged, in memory order. Each flit is presented on a valid/ready output. A flit offered while `tok_ready` is low stays on the bus unchanged until it is taken. The block has only one source, so flits of different packets are never interleaved. A small credit-managed prefetch queue between the memory read port and the bus hides the one-cycle read latency. This lets flits stream at one per cycle while `tok_ready` stays high.

The trigger is also valid/ready. The block refuses a new trigger while a sequence is running. When a sequence ends, `seq_done` pulses once. A count of zero produces no flits and only the done pulse.

Top module: `tok_burst_seq`

## Requirements
- R1: After reset, `trig_ready` is 1, and `tok_valid`, `seq_done` and `mem_rd_en` are 0.
- R2: A trigger accepted (`trig_valid` and `trig_ready` both high at a clock edge) with count N>0 emits exactly 2N flits. Flit k (k = 0 … 2N-1) carries, unchanged, the memory word at address (base + k) modulo 2^ADDR_W.
- R3: Words at even offsets (base + 2j) are the first flit of token j and are marked `tok_first`=1. Words at odd offsets are second flits and are marked `tok_first`=0, so the marks alternate 1,0,1,0 over accepted flits.
- R4: While `tok_valid` is high and `tok_ready` is low, the next cycle still shows `tok_valid` high with the same `tok_flit` and `tok_first`.
- R5: `trig_ready` is low from the edge that accepts a nonzero-count trigger until the edge that accepts that sequence's last flit. A trigger asserted in that window has no effect on the flits emitted.
- R6: `seq_done` is high for exactly the one cycle that follows the edge that accepts the final flit, and `trig_ready` is high in that cycle.
- R7: A trigger with count 0 emits no flit and issues no memory read. It raises `seq_done` for the single cycle after the accepting edge, and `trig_ready` stays high.
- R8: The memory port has one cycle of read latency: the word for address `mem_rd_addr` is taken from `mem_rd_data` one cycle after `mem_rd_en`. Reads occur only while a sequence is active.
- R9: With `tok_ready` held high, once the first flit of a sequence appears, all 2N flits are offered on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_valid | input | 1 | Trigger request |
| trig_ready | output | 1 | Block idle and able to take a trigger |
| trig_base | input | ADDR_W | First memory word address of the sequence |
| trig_count | input | CNT_W | Number of two-flit tokens to emit |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read word address |
| mem_rd_data | input | 16 | Read word, valid one cycle after the strobe |
| tok_valid | output | 1 | Flit on the bus is valid |
| tok_ready | input | 1 | Bus accepts the flit this cycle |
| tok_flit | output | 16 | Flit value |
| tok_first | output | 1 | 1 for the first flit of a token, 0 for the second |
| seq_done | output | 1 | One-cycle pulse after the final flit of a sequence is accepted |

## Verification
The assertions assume that the memory returns a word exactly one cycle after each read strobe. They also assume that `trig_base` and `trig_count` are stable while `trig_valid` is high, and that the bus never takes a flit it was not offered. The bench's memory model is a registered array that answers every strobe on the next edge. The bench changes trigger fields and `tok_ready` only at falling edges. It drops a spurious trigger in the same cycle that the final flit is taken, so that no stray trigger is accepted once the block becomes idle again.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  localparam int FLIT_W = 16;

  typedef struct packed {
    logic              first;
    logic [FLIT_W-1:0] data;
  } flit_t;

  localparam int FLIT_T_W = FLIT_W + 1;
endpackage

// File: rtl/tbs_addr_gen.sv
module tbs_addr_gen #(
  parameter int ADDR_W = 8,
  parameter int NF_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [NF_W-1:0]   nflits,
  input  logic              space,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_first
);
  logic [ADDR_W-1:0] addr_q;
  logic [NF_W-1:0]   left_q;
  logic              first_q;

  assign rd_en    = (left_q != '0) && space;
  assign rd_addr  = addr_q;
  assign rd_first = first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      left_q  <= '0;
      first_q <= 1'b1;
    end else if (start) begin
      addr_q  <= base;
      left_q  <= nflits;
      first_q <= 1'b1;
    end else if (rd_en) begin
      addr_q  <= addr_q + 1'b1;
      left_q  <= left_q - 1'b1;
      first_q <= ~first_q;
    end
  end
endmodule

// File: rtl/tbs_flit_fifo.sv
module tbs_flit_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (cnt_q != CW'(DEPTH));
  assign dout    = slot_q[rd_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tbs_emit_ctl.sv
module tbs_emit_ctl #(
  parameter int NF_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NF_W-1:0] nflits,
  input  logic            accept,
  output logic            busy,
  output logic            done
);
  logic [NF_W-1:0] left_q;
  logic            busy_q, done_q;

  assign busy = busy_q;
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        left_q <= nflits;
        busy_q <= (nflits != '0);
        done_q <= (nflits == '0);
      end else if (accept && busy_q) begin
        left_q <= left_q - 1'b1;
        if (left_q == NF_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tok_burst_seq.sv
module tok_burst_seq #(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [ADDR_W-1:0] trig_base,
  input  logic [CNT_W-1:0]  trig_count,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [15:0]       mem_rd_data,
  output logic              tok_valid,
  input  logic              tok_ready,
  output logic [15:0]       tok_flit,
  output logic              tok_first,
  output logic              seq_done
);
  import tbs_pkg::*;

  localparam int NF_W = CNT_W + 1;
  localparam int QC_W = $clog2(FIFO_DEPTH + 1);

  logic            start, busy, space, rd_first, accept, q_empty;
  logic [NF_W-1:0] nflits;
  logic            rvld_q, rfirst_q;
  logic [QC_W-1:0] q_cnt;
  flit_t           q_in, q_out;
  logic [QC_W:0]   committed;

  assign trig_ready = !busy;
  assign start      = trig_valid && trig_ready;
  assign nflits     = {trig_count, 1'b0};

  assign committed  = {1'b0, q_cnt} + (QC_W+1)'(rvld_q);
  assign space      = committed < (QC_W+1)'(FIFO_DEPTH);

  tbs_addr_gen #(.ADDR_W(ADDR_W), .NF_W(NF_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start), .base(trig_base),
    .nflits(nflits), .space(space), .rd_en(mem_rd_en),
    .rd_addr(mem_rd_addr), .rd_first(rd_first)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q   <= 1'b0;
      rfirst_q <= 1'b0;
    end else begin
      rvld_q <= mem_rd_en;
      if (mem_rd_en) rfirst_q <= rd_first;
    end
  end

  assign q_in.first = rfirst_q;
  assign q_in.data  = mem_rd_data;

  tbs_flit_fifo #(.W(FLIT_T_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(rvld_q), .din(q_in),
    .pop(accept), .dout(q_out), .empty(q_empty), .count(q_cnt)
  );

  assign tok_valid = !q_empty;
  assign tok_flit  = q_out.data;
  assign tok_first = q_out.first;
  assign accept    = tok_valid && tok_ready;

  tbs_emit_ctl #(.NF_W(NF_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .nflits(nflits),
    .accept(accept), .busy(busy), .done(seq_done)
  );
endmodule

// File: rtl/tok_burst_seq_chk.sv
module tok_burst_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_valid,
  input logic             trig_ready,
  input logic [CNT_W-1:0] trig_count,
  input logic             mem_rd_en,
  input logic             tok_valid,
  input logic             tok_ready,
  input logic [15:0]      tok_flit,
  input logic             tok_first,
  input logic             seq_done
);
  logic exp_first_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_first_q <= 1'b1;
    else if (tok_valid && tok_ready) exp_first_q <= ~exp_first_q;
  end

  // R3
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |-> (tok_first == exp_first_q));

  // R4
  hold_flit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_ready) |=> (tok_valid && $stable(tok_flit) && $stable(tok_first)));

  // R5
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |-> !trig_ready);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (trig_ready && !tok_valid));

  // R7
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_ready && trig_count == '0) |=> (seq_done && trig_ready));

  // R8
  read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !trig_ready);
endmodule

bind tok_burst_seq tok_burst_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
  .trig_count(trig_count), .mem_rd_en(mem_rd_en), .tok_valid(tok_valid),
  .tok_ready(tok_ready), .tok_flit(tok_flit), .tok_first(tok_first),
  .seq_done(seq_done)
);

// File: tb/tb_tok_burst_seq.sv
module tb_tok_burst_seq;
  localparam int PERIOD = 10;
  localparam int AW = 8;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic trig_valid = 0, trig_ready;
  logic [AW-1:0] trig_base = '0;
  logic [CW-1:0] trig_count = '0;
  logic mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [15:0] mem_rd_data;
  logic tok_valid, tok_ready = 0, tok_first, seq_done;
  logic [15:0] tok_flit;

  int checks = 0, fails = 0;
  logic [15:0] mem [1<<AW];

  always #(PERIOD/2) clk = ~clk;

  tok_burst_seq #(.ADDR_W(AW), .CNT_W(CW), .FIFO_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_base(trig_base), .trig_count(trig_count), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .tok_valid(tok_valid),
    .tok_ready(tok_ready), .tok_flit(tok_flit), .tok_first(tok_first),
    .seq_done(seq_done)
  );

  function automatic logic [15:0] word_of(input int a);
    return {8'(a), ~8'(a)} ^ 16'h3C5A;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(trig_ready == 1'b1, "R1 trig_ready", trig_ready, 1);
    chk(tok_valid == 1'b0, "R1 tok_valid", tok_valid, 0);
    chk(seq_done == 1'b0, "R1 seq_done", seq_done, 0);
    chk(mem_rd_en == 1'b0, "R1 mem_rd_en", mem_rd_en, 0);
  endtask

  // mode 0: ready always high; 1: stalling pattern; 2: stalling + spurious trigger
  task automatic run_burst(input int base, input int n, input int mode);
    int k = 0, guard = 0, gaps = 0, bad_data = 0, bad_first = 0, hold_bad = 0;
    int busy_bad = 0, done_bad = 0;
    bit seen = 0, prev_hold = 0;
    logic [15:0] prev_flit;
    @(negedge clk);
    chk(trig_ready == 1'b1, "R5 idle before trigger", trig_ready, 1);
    trig_valid = 1; trig_base = AW'(base); trig_count = CW'(n);
    @(negedge clk);
    trig_valid = 0;
    chk(trig_ready == 1'b0, "R5 busy after trigger", trig_ready, 0);
    while (k < 2*n && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (seq_done) done_bad++;
      if (trig_ready) busy_bad++;
      if (mode == 2) begin
        trig_valid = 1; trig_base = AW'(base + 77); trig_count = 8'd3;
      end
      tok_ready = (mode == 0) ? 1'b1 : ((guard % 3) != 0);
      if (prev_hold && !(tok_valid && tok_flit == prev_flit)) hold_bad++;
      if (seen && !tok_valid) gaps++;
      if (tok_valid) begin
        seen = 1;
        if (tok_ready) begin
          if (tok_flit != word_of((base + k) % (1<<AW))) bad_data++;
          if (tok_first != ((k % 2) == 0)) bad_first++;
          k++;
          prev_hold = 0;
          if (k == 2*n) trig_valid = 0;
        end else begin
          prev_hold = 1; prev_flit = tok_flit;
        end
      end else prev_hold = 0;
    end
    chk(k == 2*n, "R2 flit count", k, 2*n);
    chk(bad_data == 0, "R2 flit contents", bad_data, 0);
    chk(bad_first == 0, "R3 first-flit marks", bad_first, 0);
    chk(hold_bad == 0, "R4 hold under stall", hold_bad, 0);
    chk(busy_bad == 0, "R5 trig_ready low while active", busy_bad, 0);
    chk(done_bad == 0, "R6 no early done", done_bad, 0);
    if (mode == 0) chk(gaps == 0, "R9 gapless stream", gaps, 0);
    @(negedge clk);
    trig_valid = 0;
    tok_ready = 0;
    chk(seq_done == 1'b1, "R6 done pulse", seq_done, 1);
    chk(trig_ready == 1'b1, "R6 idle with done", trig_ready, 1);
    chk(tok_valid == 1'b0, "R5 no flit from refused trigger", tok_valid, 0);
    @(negedge clk);
    chk(seq_done == 1'b0, "R6 done single cycle", seq_done, 0);
    chk(tok_valid == 1'b0 && mem_rd_en == 1'b0, "R8 no reads after end",
        {tok_valid, mem_rd_en}, 0);
  endtask

  task automatic test_zero();
    @(negedge clk);
    trig_valid = 1; trig_base = 8'h10; trig_count = '0;
    @(negedge clk);
    trig_valid = 0;
    chk(seq_done == 1'b1, "R7 done on zero count", seq_done, 1);
    chk(trig_ready == 1'b1, "R7 stays ready", trig_ready, 1);
    chk(mem_rd_en == 1'b0, "R7 no read", mem_rd_en, 0);
    @(negedge clk);
    chk(seq_done == 1'b0, "R7 done single cycle", seq_done, 0);
    chk(tok_valid == 1'b0, "R7 no flit", tok_valid, 0);
  endtask

  task automatic test_latency();
    int wait_n = 0;
    @(negedge clk);
    trig_valid = 1; trig_base = 8'h40; trig_count = 8'd1; tok_ready = 0;
    @(negedge clk);
    trig_valid = 0;
    while (!tok_valid && wait_n < 20) begin @(negedge clk); wait_n++; end
    // start edge, read edge, data edge: first flit visible two negedges later
    chk(wait_n == 2, "R8 read latency", wait_n, 2);
    tok_ready = 1;
    @(negedge clk); @(negedge clk);
    tok_ready = 0;
    chk(seq_done == 1'b1, "R8 burst completes", seq_done, 1);
    @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < (1<<AW); a++) mem[a] = word_of(a);
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    run_burst(8'h20, 8, 0);
    run_burst(8'h03, 5, 1);
    run_burst(8'hFA, 4, 0);   // address wrap
    run_burst(8'h80, 6, 2);
    test_zero();
    test_latency();
    run_burst(8'h11, 1, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule